// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only, three-wire setup port. Its inputs are an active-low select, a serial clock and a serial data line. It fills a small set of control fields that a downstream serializer and its output drivers read. A host lowers the select, clocks in one 8-bit word, and raises the select again. The first four bits of the word name a register and the last four carry its contents.

Capture runs on the serial clock. The finished word is only acted on when the select returns high. A two-flop synchronizer carries the select edge into the sample-clock domain, and on that edge a single-cycle commit strobe writes the decoded fields. The register file discards a frame that did not hold exactly eight clocks, and it also discards a frame aimed at an address it does not implement. Every field clears to zero on the active-low reset.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst_n` is low, every output field reads 0. The fields stay 0 after reset releases until a valid frame is committed.
- R2: A frame is the bits sampled on rising `sclk` edges while `cs_n` is low. The first bit is the word MSB. The first four bits form the address and the last four form the data. `sclk` edges while `cs_n` is high shift nothing.
- R3: Address 0 sets the pattern select and the drive code. Data bits 3:2 go to `pat_sel` (00 normal, 01 deskew, 10 sync, 11 custom). Data bits 1:0 go to `drv_code`.
- R4: Address 1 sets two fields. Data bit 2 goes to `msb_first` and data bit 0 goes to `clk_drv_dbl`. Data bits 3 and 1 have no effect.
- R5: Addresses 2 and 3 hold the channel power-down bits, where 1 means powered down. Address 2 bit 0 drives `ch_pd[0]` and bit 2 drives `ch_pd[1]`. Address 3 bit 1 drives `ch_pd[2]` and bit 3 drives `ch_pd[3]`. A write to one of these addresses leaves the other address's channels unchanged.
- R6: Addresses 4, 5 and 6 load `custom_pat[3:0]`, `custom_pat[7:4]` and `custom_pat[11:8]`, each from the 4 data bits.
- R7: Address 7 data bit 0 sets `clkmon_dis`.
- R8: A committed value appears on the outputs from the third rising `smp_clk` edge after `cs_n` rises. The outputs hold their old value through the second edge, and they never change without a commit.
- R9: A frame with any count of `sclk` rising edges other than 8 changes no output.
- R10: A frame addressed to 8 through 15 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock; the domain of all outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data, MSB first |
| pat_sel | output | 2 | Output pattern select |
| drv_code | output | 2 | Data driver current code |
| msb_first | output | 1 | Bit order: 1 sends MSB first |
| clk_drv_dbl | output | 1 | Doubles the clock driver current |
| ch_pd | output | 4 | Per-channel power-down |
| custom_pat | output | 12 | Custom test word |
| clkmon_dis | output | 1 | Clock monitor disable |

## Verification
The properties assume that `cs_n` stays high for at least three sample-clock cycles after it rises. They also assume that `sclk` is quiet during that time, so the captured word and bit count are steady when the commit strobe samples them. The stimulus keeps to both conditions. Every frame is followed by a wait of well over three sample cycles. The serial clock idles low. The select is raised one nanosecond after a sample-clock edge, so the three-edge latency can be checked at exact edges. Frames of 1, 7, 9 and 16 bits, spare addresses, and `sclk` toggles with the select high all exercise the paths that must leave the fields untouched.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 4;
  localparam int WORD_W  = ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(WORD_W) + 1;
  localparam int NUM_CH  = 4;
  localparam int PAT_NIB = 3;
  localparam int PAT_W   = PAT_NIB * DATA_W;

  typedef enum logic [1:0] {
    PAT_NORMAL = 2'b00,
    PAT_DESKEW = 2'b01,
    PAT_SYNC   = 2'b10,
    PAT_CUSTOM = 2'b11
  } pat_sel_e;

  typedef enum logic [ADDR_W-1:0] {
    A_OUTMODE = 4'd0,
    A_ORDER   = 4'd1,
    A_PD_LO   = 4'd2,
    A_PD_HI   = 4'd3,
    A_CUST0   = 4'd4,
    A_CUST1   = 4'd5,
    A_CUST2   = 4'd6,
    A_MISC    = 4'd7
  } reg_addr_e;

  typedef struct packed {
    logic              clkmon_dis;
    logic [PAT_W-1:0]  custom;
    logic [NUM_CH-1:0] ch_pd;
    logic              clk_dbl;
    logic              msb_first;
    logic [1:0]        drv;
    pat_sel_e          pat;
  } cfg_t;
endpackage

// File: rtl/cfg_shift_rx.sv
module cfg_shift_rx
  import cfg_port_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sdata,
  output logic [WORD_W-1:0] frm_word,
  output logic [CNT_W-1:0]  frm_len
);
  localparam logic [CNT_W-1:0] LEN_MAX = {CNT_W{1'b1}};

  logic              fresh_q;
  logic              shift_en;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  len_q, len_d;

  // Marks that the next sclk edge opens a new frame; set whenever select is high.
  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n)    fresh_q <= 1'b1;
    else if (cs_n) fresh_q <= 1'b1;
    else           fresh_q <= 1'b0;
  end

  assign shift_en = !cs_n;

  always_comb begin
    word_d = word_q;
    len_d  = len_q;
    if (fresh_q) begin
      word_d = {{(WORD_W-1){1'b0}}, sdata};
      len_d  = CNT_W'(1);
    end else begin
      word_d = {word_q[WORD_W-2:0], sdata};
      if (len_q != LEN_MAX) len_d = len_q + CNT_W'(1);
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      len_q  <= '0;
    end else if (shift_en) begin
      word_q <= word_d;
      len_q  <= len_d;
    end
  end

  assign frm_word = word_q;
  assign frm_len  = len_q;
endmodule

// File: rtl/cfg_cdc_sync.sv
module cfg_cdc_sync #(
  parameter int STAGES = 2
) (
  input  logic smp_clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic rst_s_n,
  output logic commit
);
  logic [STAGES-1:0] rst_pipe_q, rst_pipe_d;
  logic [STAGES:0]   cs_pipe_q, cs_pipe_d;

  // Reset: asserted at once, released after STAGES sample edges.
  always_comb rst_pipe_d = {rst_pipe_q[STAGES-2:0], 1'b1};

  always_ff @(posedge smp_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_s_n = rst_pipe_q[STAGES-1];

  // Select synchronizer plus one history flop for edge detection.
  always_comb cs_pipe_d = {cs_pipe_q[STAGES-1:0], cs_n};

  always_ff @(posedge smp_clk or negedge rst_s_n) begin
    if (!rst_s_n) cs_pipe_q <= '1;
    else          cs_pipe_q <= cs_pipe_d;
  end

  assign commit = cs_pipe_q[STAGES-1] & ~cs_pipe_q[STAGES];
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
(
  input  logic              smp_clk,
  input  logic              rst_s_n,
  input  logic              commit,
  input  logic [CNT_W-1:0]  frm_len,
  input  logic [WORD_W-1:0] frm_word,
  output cfg_t              cfg
);
  logic              wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign wr_ok   = commit && (frm_len == CNT_W'(WORD_W));
  assign wr_addr = frm_word[WORD_W-1 -: ADDR_W];
  assign wr_data = frm_word[DATA_W-1:0];

  // Output mode: pattern select and driver code.
  logic              mode_en;
  logic [DATA_W-1:0] mode_q, mode_d;
  assign mode_en = wr_ok && (wr_addr == A_OUTMODE);
  always_comb mode_d = mode_en ? wr_data : mode_q;
  always_ff @(posedge smp_clk or negedge rst_s_n) begin
    if (!rst_s_n) mode_q <= '0;
    else          mode_q <= mode_d;
  end

  // Bit order and clock driver doubling.
  logic order_en;
  logic msb_q, msb_d, dbl_q, dbl_d;
  assign order_en = wr_ok && (wr_addr == A_ORDER);
  always_comb begin
    msb_d = order_en ? wr_data[2] : msb_q;
    dbl_d = order_en ? wr_data[0] : dbl_q;
  end
  always_ff @(posedge smp_clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      msb_q <= 1'b0;
      dbl_q <= 1'b0;
    end else begin
      msb_q <= msb_d;
      dbl_q <= dbl_d;
    end
  end

  // Channel power-down: channel c sits at address A_PD_LO + c/2, bit 2*(c%2) + c/2.
  logic [NUM_CH-1:0] pd_vec;
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pd
    localparam int PD_ADDR = int'(A_PD_LO) + c / 2;
    localparam int PD_BIT  = (c % 2) * 2 + c / 2;
    logic pd_en, pd_q, pd_d;
    assign pd_en = wr_ok && (wr_addr == ADDR_W'(PD_ADDR));
    always_comb pd_d = pd_en ? wr_data[PD_BIT] : pd_q;
    always_ff @(posedge smp_clk or negedge rst_s_n) begin
      if (!rst_s_n) pd_q <= 1'b0;
      else          pd_q <= pd_d;
    end
    assign pd_vec[c] = pd_q;
  end

  // Custom pattern nibbles, lowest address feeds lowest bits.
  logic [PAT_W-1:0] cust_vec;
  for (genvar n = 0; n < PAT_NIB; n++) begin : g_nib
    logic              nib_en;
    logic [DATA_W-1:0] nib_q, nib_d;
    assign nib_en = wr_ok && (wr_addr == ADDR_W'(int'(A_CUST0) + n));
    always_comb nib_d = nib_en ? wr_data : nib_q;
    always_ff @(posedge smp_clk or negedge rst_s_n) begin
      if (!rst_s_n) nib_q <= '0;
      else          nib_q <= nib_d;
    end
    assign cust_vec[n*DATA_W +: DATA_W] = nib_q;
  end

  // Clock monitor disable.
  logic misc_en, mon_q, mon_d;
  assign misc_en = wr_ok && (wr_addr == A_MISC);
  always_comb mon_d = misc_en ? wr_data[0] : mon_q;
  always_ff @(posedge smp_clk or negedge rst_s_n) begin
    if (!rst_s_n) mon_q <= 1'b0;
    else          mon_q <= mon_d;
  end

  always_comb begin
    cfg.pat        = pat_sel_e'(mode_q[3:2]);
    cfg.drv        = mode_q[1:0];
    cfg.msb_first  = msb_q;
    cfg.clk_dbl    = dbl_q;
    cfg.ch_pd      = pd_vec;
    cfg.custom     = cust_vec;
    cfg.clkmon_dis = mon_q;
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              smp_clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [1:0]        pat_sel,
  output logic [1:0]        drv_code,
  output logic              msb_first,
  output logic              clk_drv_dbl,
  output logic [NUM_CH-1:0] ch_pd,
  output logic [PAT_W-1:0]  custom_pat,
  output logic              clkmon_dis
);
  logic [WORD_W-1:0] frm_word;
  logic [CNT_W-1:0]  frm_len;
  logic              rst_s_n;
  logic              commit;
  cfg_t              cfg;

  cfg_shift_rx i_rx (
    .sclk     (sclk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdata    (sdata),
    .frm_word (frm_word),
    .frm_len  (frm_len)
  );

  cfg_cdc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .smp_clk (smp_clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rst_s_n (rst_s_n),
    .commit  (commit)
  );

  cfg_regfile i_regs (
    .smp_clk  (smp_clk),
    .rst_s_n  (rst_s_n),
    .commit   (commit),
    .frm_len  (frm_len),
    .frm_word (frm_word),
    .cfg      (cfg)
  );

  assign pat_sel     = cfg.pat;
  assign drv_code    = cfg.drv;
  assign msb_first   = cfg.msb_first;
  assign clk_drv_dbl = cfg.clk_dbl;
  assign ch_pd       = cfg.ch_pd;
  assign custom_pat  = cfg.custom;
  assign clkmon_dis  = cfg.clkmon_dis;
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk
  import cfg_port_pkg::*;
(
  input logic              smp_clk,
  input logic              rst_n,
  input logic              commit,
  input logic [CNT_W-1:0]  frm_len,
  input logic [WORD_W-1:0] frm_word,
  input logic [1:0]        pat_sel,
  input logic [1:0]        drv_code,
  input logic              msb_first,
  input logic              clk_drv_dbl,
  input logic [NUM_CH-1:0] ch_pd,
  input logic [PAT_W-1:0]  custom_pat,
  input logic              clkmon_dis
);
  logic [PAT_W+NUM_CH+6:0] outs;
  assign outs = {clkmon_dis, custom_pat, ch_pd, clk_drv_dbl, msb_first, drv_code, pat_sel};

  logic good_len;
  assign good_len = (frm_len == CNT_W'(WORD_W));

  // R1: fields read zero while reset is held
  always @(posedge smp_clk) begin
    if (!rst_n) p_reset_clear_r1: assert (outs == '0);
  end

  p_hold_without_commit_r8: assert property (@(posedge smp_clk) disable iff (!rst_n)
    !commit |=> $stable(outs));

  p_bad_length_drop_r9: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (commit && !good_len) |=> $stable(outs));

  p_spare_addr_drop_r10: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (commit && frm_word[WORD_W-1]) |=> $stable(outs));

  p_mode_write_r3: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (commit && good_len && frm_word[WORD_W-1 -: ADDR_W] == 4'd0)
    |=> ({pat_sel, drv_code} == $past(frm_word[DATA_W-1:0])));

  p_nibble_write_r6: assert property (@(posedge smp_clk) disable iff (!rst_n)
    (commit && good_len && frm_word[WORD_W-1 -: ADDR_W] == 4'd4)
    |=> (custom_pat[DATA_W-1:0] == $past(frm_word[DATA_W-1:0])));
endmodule

bind cfg_serial_port cfg_serial_port_chk i_chk (
  .smp_clk     (smp_clk),
  .rst_n       (rst_n),
  .commit      (commit),
  .frm_len     (frm_len),
  .frm_word    (frm_word),
  .pat_sel     (pat_sel),
  .drv_code    (drv_code),
  .msb_first   (msb_first),
  .clk_drv_dbl (clk_drv_dbl),
  .ch_pd       (ch_pd),
  .custom_pat  (custom_pat),
  .clkmon_dis  (clkmon_dis)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;
  logic        smp_clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic        sclk;
  logic        sdata;
  logic [1:0]  pat_sel;
  logic [1:0]  drv_code;
  logic        msb_first;
  logic        clk_drv_dbl;
  logic [3:0]  ch_pd;
  logic [11:0] custom_pat;
  logic        clkmon_dis;

  cfg_serial_port i_cfg_serial_port (
    .smp_clk     (smp_clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .sdata       (sdata),
    .pat_sel     (pat_sel),
    .drv_code    (drv_code),
    .msb_first   (msb_first),
    .clk_drv_dbl (clk_drv_dbl),
    .ch_pd       (ch_pd),
    .custom_pat  (custom_pat),
    .clkmon_dis  (clkmon_dis)
  );

  always #2 smp_clk = ~smp_clk;

  // Packed view: [22] mon, [21:10] custom, [9:6] pd, [5] dbl, [4] msb, [3:2] drv, [1:0] pat
  logic [22:0] dut_vec;
  assign dut_vec = {clkmon_dis, custom_pat, ch_pd, clk_drv_dbl, msb_first, drv_code, pat_sel};

  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;
  logic [22:0] model = '0;
  logic [22:0] exp_q[$];
  string       tag_q[$];
  logic [22:0] last_seen = '0;

  function automatic logic [22:0] apply(input logic [22:0] m, input logic [3:0] a,
                                         input logic [3:0] d);
    logic [22:0] r = m;
    case (a)
      4'd0: begin r[1:0] = d[3:2]; r[3:2] = d[1:0]; end
      4'd1: begin r[4] = d[2]; r[5] = d[0]; end
      4'd2: begin r[6] = d[0]; r[7] = d[2]; end
      4'd3: begin r[8] = d[1]; r[9] = d[3]; end
      4'd4: r[13:10] = d;
      4'd5: r[17:14] = d;
      4'd6: r[21:18] = d;
      4'd7: r[22] = d[0];
      default: ;
    endcase
    return r;
  endfunction

  task automatic check(input logic [22:0] act, input logic [22:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: each output change must match the next queued item.
  always @(negedge smp_clk) begin
    if (rst_n === 1'b1 && dut_vec !== last_seen) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8 unexpected change actual=%h expected=%h", dut_vec, last_seen);
      end else begin
        check(dut_vec, exp_q.pop_front(), tag_q.pop_front());
      end
    end
    last_seen = dut_vec;
  end

  // Driver: one frame of nbits serial clocks, then select release and latency check.
  task automatic send(input logic [3:0] a, input logic [3:0] d, input int nbits,
                      input string tag);
    logic [7:0]  w = {a, d};
    logic [22:0] exp;
    cs_n = 1'b0;
    #10;
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 8) ? w[3'(7 - i)] : 1'b1;
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
    end
    #10;
    @(posedge smp_clk);
    #1 cs_n = 1'b1;
    exp = (nbits == 8 && a < 4'd8) ? apply(model, a, d) : model;
    if (exp != model) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    repeat (3) @(negedge smp_clk);
    check(dut_vec, model, {"R8 before third edge ", tag});
    @(negedge smp_clk);
    check(dut_vec, exp, tag);
    model = exp;
    repeat (6) @(negedge smp_clk);
  endtask

  initial begin
    #400000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    rst_n = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdata = 1'b0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge smp_clk);
    check(dut_vec, '0, "R1 reset state");
    rst_n = 1'b1;
    repeat (5) @(negedge smp_clk);
    check(dut_vec, '0, "R1 after release");

    send(4'd0, 4'b1001, 8, "R3 sync pattern drive 01");
    send(4'd0, 4'b0111, 8, "R3 deskew pattern drive 11");
    send(4'd0, 4'b1100, 8, "R3 custom pattern drive 00");
    send(4'd1, 4'b0100, 8, "R4 msb first");
    send(4'd1, 4'b1011, 8, "R4 clock double, bits 3 and 1 ignored");
    send(4'd2, 4'b0101, 8, "R5 pd ch0 ch1");
    send(4'd3, 4'b1010, 8, "R5 pd ch2 ch3");
    send(4'd2, 4'b1010, 8, "R5 clear ch0 ch1, keep ch2 ch3");
    send(4'd4, 4'h5, 8, "R6 nibble 0");
    send(4'd5, 4'hA, 8, "R6 nibble 1");
    send(4'd6, 4'hC, 8, "R6 nibble 2");
    send(4'd7, 4'h1, 8, "R7 monitor disable set");
    send(4'd7, 4'hE, 8, "R7 monitor disable clear");

    send(4'd0, 4'h3, 7, "R9 seven clocks");
    send(4'd0, 4'h3, 9, "R9 nine clocks");
    send(4'd4, 4'h0, 1, "R9 one clock");
    send(4'd4, 4'h0, 16, "R9 sixteen clocks");
    send(4'd8, 4'hF, 8, "R10 address 8");
    send(4'd12, 4'hF, 8, "R10 address 12");
    send(4'd15, 4'h0, 8, "R10 address 15");

    // R2: sclk toggles with the select high shift nothing
    sdata = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #10 sclk = 1'b1;
      #10 sclk = 1'b0;
    end
    repeat (6) @(negedge smp_clk);
    check(dut_vec, model, "R2 idle sclk ignored");
    send(4'd5, 4'h3, 8, "R2 frame after idle clocks");
    send(4'd0, 4'b0110, 8, "R2 address and data split");

    // R1: reset mid-run clears all fields
    @(negedge smp_clk) rst_n = 1'b0;
    repeat (2) @(negedge smp_clk);
    check(dut_vec, '0, "R1 reset mid-run");
    model = '0;
    rst_n = 1'b1;
    repeat (5) @(negedge smp_clk);
    check(dut_vec, '0, "R1 held after release");
    send(4'd6, 4'h9, 8, "R6 write after reset");

    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R8 pending items actual=%0d expected=0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule